// File: doc/BRIEF.md
# Three-Wire Serial Bus Master

This block drives a three-wire synchronous serial bus. The bus has a chip-enable line, a serial clock and one shared data line. Each host request moves a single byte to or from a 6-bit register address on the slave. The host pulses `start_i` with a direction flag, an address and, for a write, a data byte. The controller raises chip enable and shifts out a command byte. It then either shifts out the data byte or releases the data line and captures the byte the slave returns.

The data line appears at the ports as three signals: an output value, an output enable and an input sample. A pad or a tri-state buffer outside the block combines them. The serial bit rate comes from the `HALF_CYC` parameter, which sets the length of each serial-clock half-period in system clock cycles. A transaction lasts 33 half-periods. These are 16 bit periods of two halves each, followed by one hold half-period. When the transaction ends, `done_o` pulses for one cycle. On a read, `rdata_o` updates in that same cycle.

Top module: `tw_serial_master`

## Requirements
- R1: Out of reset and between transactions, `ce_o`, `sclk_o` and `sio_o` are low, `sio_oe_o` is high, `busy_o` and `done_o` are low, and `rdata_o` is 0x00.
- R2: The first byte shifted is the command byte. Bit 7 is 1, bits 6:1 hold `addr_i[5:0]`, and bit 0 is 1 for a read (`rw_i`=1) and 0 for a write. It is sent LSB first.
- R3: In each bit period, the data bit is placed on `sio_o` while `sclk_o` is low for one half-period. `sclk_o` then stays high for one half-period while `sio_o` holds steady.
- R4: On a write, the second byte is `wdata_i` as it was sampled with `start_i`, shifted LSB first.
- R5: On a read, `sio_oe_o` goes low after the eighth command bit and stays low until chip enable drops. `sio_i` is sampled in the last system cycle of each low half of the data byte. The sampled bits are assembled LSB first into `rdata_o`.
- R6: `ce_o` is high for exactly 33 half-periods from the cycle after an accepted start. This gives at least one half-period of setup before the first rising edge of `sclk_o` and one half-period of hold after the last falling edge. `sclk_o` is never high while `ce_o` is low.
- R7: `busy_o` is high for the whole transaction. In the cycle where it falls, `done_o` is high for exactly one cycle.
- R8: A `start_i` that arrives while `busy_o` is high is ignored and does not change the transaction in progress.
- R9: `rdata_o` changes only when a read completes. A write leaves it unchanged.
- R10: Every high and low half-period of `sclk_o` lasts `HALF_CYC` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a transaction (accepted only when idle) |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 6 | Slave register address |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Last byte read |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ce_o | output | 1 | Bus chip enable |
| sclk_o | output | 1 | Bus serial clock |
| sio_o | output | 1 | Data line output value |
| sio_oe_o | output | 1 | Data line output enable |
| sio_i | input | 1 | Data line input sample |

## Verification
An accepted start is the edge where `start_i` is seen high while idle. Counting from the cycle after that edge, cycle k belongs to half-period k / `HALF_CYC`. Chip enable, clock, data and output enable must take the values of that half-period in cycle k. `busy_o` falls and `done_o` and a read's `rdata_o` appear in cycle 33·`HALF_CYC`. The bench keeps its own counter of k from the start it saw and predicts every output for the current cycle. It compares them on the falling clock edge, after the registers have settled. The slave model puts the correct bit on `sio_i` only during the low half of each read bit and the inverted bit during the high half, so a sample taken in the wrong half-period shows up in `rdata_o`.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned BIT_COUNT = 2 * BYTE_W;       // command + data
  localparam int unsigned PH_HOLD   = 2 * BIT_COUNT;    // final hold half-period
  localparam int unsigned PH_W      = $clog2(PH_HOLD + 1);

  function automatic logic [BYTE_W-1:0] make_cmd(input logic [ADDR_W-1:0] a, input logic rd);
    return {1'b1, a, rd};
  endfunction
endpackage

// File: rtl/tw_clk_div.sv
module tw_clk_div #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_cnt_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/tw_bit_seq.sv
module tw_bit_seq
  import tw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              sio_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ce_o,
  output logic              sclk_o,
  output logic              sio_o,
  output logic              sio_oe_o
);
  localparam logic [PH_W-1:0] HOLD = PH_W'(PH_HOLD);
  localparam logic [PH_W-1:0] DATA = PH_W'(2 * BYTE_W);

  logic [PH_W-1:0]   ph_q;
  logic              rd_q;
  logic [BYTE_W-1:0] cmd_q, wd_q, sh_q;
  logic              in_shift, in_data, rd_phase;
  logic [2:0]        bidx;

  assign in_shift = ph_q < HOLD;
  assign in_data  = (ph_q >= DATA) && in_shift;
  assign bidx     = ph_q[3:1];
  assign rd_phase = busy_o && rd_q && (ph_q >= DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      ph_q    <= '0;
      rd_q    <= 1'b0;
      cmd_q   <= '0;
      wd_q    <= '0;
      sh_q    <= '0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          ph_q   <= '0;
          rd_q   <= rw_i;
          cmd_q  <= make_cmd(addr_i, rw_i);
          wd_q   <= wdata_i;
        end
      end else if (tick_i) begin
        if (ph_q == HOLD) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          if (rd_q) rdata_o <= sh_q;
        end else begin
          ph_q <= ph_q + 1'b1;
          // sample at the end of the low half, before the rising edge
          if (rd_q && in_data && !ph_q[0]) sh_q[bidx] <= sio_i;
        end
      end
    end
  end

  always_comb begin
    ce_o     = busy_o;
    sclk_o   = busy_o && in_shift && ph_q[0];
    sio_oe_o = !rd_phase;
    sio_o    = 1'b0;
    if (busy_o && in_shift) begin
      if (!in_data)   sio_o = cmd_q[bidx];
      else if (!rd_q) sio_o = wd_q[bidx];
    end
  end

  p_sclk_in_ce_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> ce_o);
  p_data_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sio_o));
  p_done_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_oe_only_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sio_oe_o |-> (busy_o && ce_o));
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(cmd_q) && $stable(wd_q));
  p_rdata_on_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ce_o && !sclk_o && !sio_o && sio_oe_o));
endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
  import tw_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rw_i,
  input  logic [5:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       ce_o,
  output logic       sclk_o,
  output logic       sio_o,
  output logic       sio_oe_o,
  input  logic       sio_i
);
  logic tick;

  tw_clk_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_o),
    .tick_o (tick)
  );

  tw_bit_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .rw_i     (rw_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .tick_i   (tick),
    .sio_i    (sio_i),
    .rdata_o  (rdata_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ce_o     (ce_o),
    .sclk_o   (sclk_o),
    .sio_o    (sio_o),
    .sio_oe_o (sio_oe_o)
  );
endmodule

// File: tb/tw_serial_master_test.sv
module tw_serial_master_test;
  localparam int H = 3;
  localparam int TOTAL = 33 * H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, rw = 1'b0, sio_in = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy, done, ce, sclk, sio, sio_oe;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  tw_serial_master #(.HALF_CYC(H)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rw_i(rw), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .done_o(done), .ce_o(ce),
    .sclk_o(sclk), .sio_o(sio), .sio_oe_o(sio_oe), .sio_i(sio_in)
  );

  // reference model
  bit       m_act = 0, m_done = 0, m_rw = 0;
  int       m_k = 0;
  bit [7:0] m_cmd = 0, m_wd = 0, m_rdata = 0;
  bit [7:0] slave_byte = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_done <= 0; m_k <= 0; m_rdata <= 0;
    end else begin
      m_done <= 0;
      if (!m_act) begin
        if (start) begin
          m_act <= 1; m_k <= 0; m_rw <= rw; m_wd <= wdata;
          m_cmd <= {1'b1, addr, rw};
        end
      end else if (m_k == TOTAL - 1) begin
        m_act <= 0; m_done <= 1;
        if (m_rw) m_rdata <= slave_byte;
      end else m_k <= m_k + 1;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  int hi_len = 0;
  always @(negedge clk) begin
    int ph, b;
    bit e_sclk, e_sio, e_oe;
    ph = m_k / H; b = ph / 2;
    e_sclk = m_act && ph < 32 && (ph % 2 == 1);
    e_oe   = !(m_act && m_rw && ph >= 16);
    e_sio  = 0;
    if (m_act && ph < 16) e_sio = m_cmd[b];
    else if (m_act && ph < 32 && !m_rw) e_sio = m_wd[b - 8];
    if (rst_n) begin
      chk(m_act ? "R6 ce" : "R1 ce", {7'd0, ce}, {7'd0, m_act});
      chk(m_act ? "R3 sclk" : "R1 sclk", {7'd0, sclk}, {7'd0, e_sclk});
      chk((m_act && ph >= 16) ? "R4 sio data" : "R2 sio cmd", {7'd0, sio}, {7'd0, e_sio});
      chk("R5 oe", {7'd0, sio_oe}, {7'd0, e_oe});
      chk("R7 busy", {7'd0, busy}, {7'd0, m_act});
      chk("R7 done", {7'd0, done}, {7'd0, m_done});
      chk("R9 rdata", rdata, m_rdata);
      if (sclk) hi_len++;
      else if (hi_len != 0) begin
        chk("R10 sclk high length", 8'(hi_len), 8'(H));
        hi_len = 0;
      end
    end
    // slave: right bit only in the low half of a read data bit
    if (m_act && m_rw && ph >= 16 && ph < 32)
      sio_in = (ph % 2 == 0) ? slave_byte[b - 8] : ~slave_byte[b - 8];
    else sio_in = 1'b0;
  end

  task automatic xfer(input bit r, input bit [5:0] a, input bit [7:0] d, input bit [7:0] sl);
    slave_byte = sl;
    @(posedge clk); #2;
    start = 1; rw = r; addr = a; wdata = d;
    @(posedge clk); #2;
    start = 0; wdata = ~d;
    while (m_act) @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset lines", {4'd0, ce, sclk, sio, busy}, 8'h00);
    rst_n = 1;
    repeat (2) @(posedge clk);
    #2;
    xfer(0, 6'h15, 8'hA5, 8'h00);        // R2 R4 write
    chk("R9 rdata after write", rdata, 8'h00);
    xfer(1, 6'h2A, 8'h00, 8'h3C);        // R5 read
    chk("R5 rdata after read", rdata, 8'h3C);
    xfer(0, 6'h3F, 8'h5E, 8'hFF);        // R9 write keeps rdata
    chk("R9 rdata held", rdata, 8'h3C);
    // R8: start while busy ignored
    slave_byte = 8'h81;
    @(posedge clk); #2;
    start = 1; rw = 1; addr = 6'h01;
    @(posedge clk); #2;
    start = 0;
    repeat (20) @(posedge clk);
    #2;
    start = 1; rw = 0; addr = 6'h33; wdata = 8'h77;
    @(posedge clk); #2;
    start = 0;
    while (m_act) @(posedge clk);
    #2;
    chk("R8 ignored start, read result", rdata, 8'h81);
    xfer(1, 6'h00, 8'h00, 8'h00);
    chk("R5 read zero", rdata, 8'h00);
    xfer(1, 6'h3F, 8'h00, 8'hFF);
    chk("R5 read ones", rdata, 8'hFF);
    repeat (5) @(posedge clk);
    #2;
    chk("R1 idle after runs", {4'd0, ce, sclk, sio, busy}, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule